// File: doc/BRIEF.md
# Floppy Controller Register and Interrupt File

This block is the host-visible register bank of a floppy disk controller. A simple byte-wide bus reads and writes sixteen registers, one every sixteen bytes of address space. The bank keeps the setup, mode, drive-line select, sector, sector-count, gap and seek-count values that the controller core consumes. It latches event pulses and error pulses from the core into sticky flag registers, and it combines the event flags with an enable mask and a master enable into one interrupt line.

The control register cannot be written directly. Software clears bits through one address and sets bits through another, so it can change single bits without a read-modify-write. Reading the interrupt flags or the error flags clears them. An event that arrives in the cycle of that read is still kept. A down-counter driven by a 1 µs prescaled tick raises the timer event when it expires. Setting the software-reset bit in the setup register holds the control, interrupt and error registers at zero.

Top module: `fdc_regfile`

## Requirements
- R1: The register is selected by address bits [7:4] as a 4-bit index, and address bits [3:0] are ignored. The index map is: 0 data, 1 timer, 2 error, 3 mode, 4 select, 5 setup, 6 control-clear, 7 status/control-set, 8 interrupt flags, 9 seek count, 10 current track, 11 current sector, 12 gap, 13 first sector, 14 sector count, 15 interrupt enable.
- R2: Mode, select, setup, seek count, gap, first sector and sector count are plain 8-bit read/write registers, and each drives its output port. The interrupt enable register keeps bits [5:0] and reads 0 in bits [7:6]. Every register resets to zero.
- R3: A write to index 6 clears each control bit that is 1 in the written byte. A read of index 6 returns the control value. Control bit 0 is the master interrupt enable.
- R4: A write to index 7 sets each control bit that is 1 in the written byte.
- R5: Interrupt flags (bit5 error, bit4 data changed, bit3 transfer done, bit2 sector seen, bit1 seek done, bit0 timer done) latch high on pulses of `irq_src_i`. A read of index 8 returns the flags and clears them. An event in the same cycle as that read stays latched.
- R6: The error register latches `err_src_i` on bits 7, 6, 2 and 0 only, and drops the other bits. A read of index 2 clears it, and an error in the same cycle as that read stays latched.
- R7: `irq_o` is high exactly while control bit 0 is set and (flags AND enable) is nonzero.
- R8: A read of index 7 returns status: bit7 `fifo1_i`, bit6 `fifo2_i`, bit5 error register nonzero, bit3 `line_i`, bit1 the `irq_o` condition, bit0 `mark_i`, and 0 in bits 4 and 2.
- R9: A write to index 1 loads the timer and restarts the prescaler. The timer then decrements once every CLK_PER_US clocks. The decrement from 1 to 0 sets flag bit0 in the same edge. At 0 the timer holds.
- R10: While setup bit 7 is set, control, interrupt flags and error are forced to zero from the next edge on. Writes to control and incoming events have no effect during that time.
- R11: Reads of index 10, 11 and 0 return `ctrack_i`, `csect_i` and `data_i`. Writes to those indices have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effects at clock edge) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address |
| data_i | input | 8 | Data byte from the core |
| ctrack_i | input | 8 | Current track from the core |
| csect_i | input | 8 | Current sector from the core |
| fifo1_i | input | 1 | FIFO holds one byte |
| fifo2_i | input | 1 | FIFO holds two bytes |
| line_i | input | 1 | Sensed drive line |
| mark_i | input | 1 | Mark byte seen |
| irq_src_i | input | 6 | Event pulses, interrupt flag layout |
| err_src_i | input | 8 | Error pulses, error register layout |
| ctrl_o | output | 8 | Control register |
| setup_o | output | 8 | Setup register |
| mode_o | output | 8 | Mode register |
| select_o | output | 8 | Drive-line select register |
| nseek_o | output | 8 | Seek count |
| gap_o | output | 8 | Gap size |
| sector_o | output | 8 | First sector |
| nsect_o | output | 8 | Sector count |
| irq_o | output | 1 | Interrupt request |

## Verification
If a flag is lost, the fault shows only when the flag register is read back or when `irq_o` stays low one cycle after the pulse. The bench therefore reads the flags in the cycle right after each event and during a concurrent event. A wrong control value shows on `ctrl_o` in the cycle after the write. A prescaler off by one shifts the timer-done edge and the `irq_o` rise by one clock. The bench samples the counter and `irq_o` on both sides of the exact expiry edge.

// File: rtl/fdc_reg_pkg.sv
package fdc_reg_pkg;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned IRQ_W = 6;
  localparam int unsigned DW    = 8;
  localparam logic [DW-1:0] ERR_MASK = 8'hC5;
  localparam int unsigned CTL_IE    = 0;
  localparam int unsigned SETUP_RST = 7;

  typedef enum logic [IDX_W-1:0] {
    RI_DATA = 4'd0, RI_TIMER, RI_ERR, RI_MODE, RI_SEL, RI_SETUP, RI_CTRL, RI_STAT,
    RI_INTR, RI_NSEEK, RI_CTRACK, RI_CSECT, RI_GAP, RI_SECTOR, RI_NSECT, RI_IEN
  } reg_idx_e;
endpackage

// File: rtl/fdc_tick_timer.sv
module fdc_tick_timer #(
  parameter int unsigned CLK_PER_US = 8,
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         done_o
);
  localparam int unsigned PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] PMAX = PW'(CLK_PER_US - 1);

  logic [PW-1:0] presc_q;
  logic [W-1:0]  cnt_q;
  logic          tick;

  assign tick   = (presc_q == PMAX);
  assign done_o = tick && !load_i && (cnt_q == W'(1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else begin
      presc_q <= (load_i || tick) ? '0 : presc_q + PW'(1);
      if (load_i)                   cnt_q <= load_val_i;
      else if (tick && cnt_q != '0) cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/fdc_sticky_flags.sv
module fdc_sticky_flags #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic         clr_i,
  input  logic         hold_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] q;

  // new events win over the clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (hold_i) q <= '0;
    else             q <= (clr_i ? '0 : q) | (ev_i & MASK);
  end

  assign flags_o = q;
endmodule

// File: rtl/fdc_ctrl_reg.sv
module fdc_ctrl_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bic_i,
  input  logic         bis_i,
  input  logic [W-1:0] wdata_i,
  input  logic         hold_i,
  output logic [W-1:0] ctrl_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (hold_i) q <= '0;
    else if (bic_i)  q <= q & ~wdata_i;
    else if (bis_i)  q <= q | wdata_i;
  end

  assign ctrl_o = q;
endmodule

// File: rtl/fdc_regfile.sv
module fdc_regfile
  import fdc_reg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned STRIDE_LOG2 = 4,
  parameter int unsigned CLK_PER_US  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     data_i,
  input  logic [DW-1:0]     ctrack_i,
  input  logic [DW-1:0]     csect_i,
  input  logic              fifo1_i,
  input  logic              fifo2_i,
  input  logic              line_i,
  input  logic              mark_i,
  input  logic [IRQ_W-1:0]  irq_src_i,
  input  logic [DW-1:0]     err_src_i,
  output logic [DW-1:0]     ctrl_o,
  output logic [DW-1:0]     setup_o,
  output logic [DW-1:0]     mode_o,
  output logic [DW-1:0]     select_o,
  output logic [DW-1:0]     nseek_o,
  output logic [DW-1:0]     gap_o,
  output logic [DW-1:0]     sector_o,
  output logic [DW-1:0]     nsect_o,
  output logic              irq_o
);
  reg_idx_e              idx;
  logic [STRIDE_LOG2-1:0] addr_unused;
  logic                  swrst;
  logic [DW-1:0]         mode_q, sel_q, setup_q, nseek_q, gap_q, sector_q, nsect_q;
  logic [IRQ_W-1:0]      ien_q, intr_q, irq_ev;
  logic [DW-1:0]         err_q, tmr_cnt, ctrl_q, status;
  logic                  tmr_done;

  assign idx         = reg_idx_e'(addr_i[STRIDE_LOG2 +: IDX_W]);
  assign addr_unused = addr_i[STRIDE_LOG2-1:0];
  assign swrst       = setup_q[SETUP_RST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; sel_q <= '0; setup_q <= '0; nseek_q <= '0;
      gap_q <= '0; sector_q <= '0; nsect_q <= '0; ien_q <= '0;
    end else if (wr_i) begin
      unique case (idx)
        RI_MODE:   mode_q   <= wdata_i;
        RI_SEL:    sel_q    <= wdata_i;
        RI_SETUP:  setup_q  <= wdata_i;
        RI_NSEEK:  nseek_q  <= wdata_i;
        RI_GAP:    gap_q    <= wdata_i;
        RI_SECTOR: sector_q <= wdata_i;
        RI_NSECT:  nsect_q  <= wdata_i;
        RI_IEN:    ien_q    <= wdata_i[IRQ_W-1:0];
        default: ;
      endcase
    end
  end

  fdc_ctrl_reg #(.W(DW)) u_ctrl (
    .clk_i, .rst_ni,
    .bic_i   (wr_i && idx == RI_CTRL),
    .bis_i   (wr_i && idx == RI_STAT),
    .wdata_i,
    .hold_i  (swrst),
    .ctrl_o  (ctrl_q)
  );

  fdc_tick_timer #(.CLK_PER_US(CLK_PER_US), .W(DW)) u_tmr (
    .clk_i, .rst_ni,
    .load_i     (wr_i && idx == RI_TIMER),
    .load_val_i (wdata_i),
    .cnt_o      (tmr_cnt),
    .done_o     (tmr_done)
  );

  assign irq_ev = irq_src_i | {{(IRQ_W-1){1'b0}}, tmr_done};

  fdc_sticky_flags #(.W(IRQ_W), .MASK('1)) u_intr (
    .clk_i, .rst_ni,
    .ev_i    (irq_ev),
    .clr_i   (rd_i && idx == RI_INTR),
    .hold_i  (swrst),
    .flags_o (intr_q)
  );

  fdc_sticky_flags #(.W(DW), .MASK(ERR_MASK)) u_err (
    .clk_i, .rst_ni,
    .ev_i    (err_src_i),
    .clr_i   (rd_i && idx == RI_ERR),
    .hold_i  (swrst),
    .flags_o (err_q)
  );

  assign irq_o  = ctrl_q[CTL_IE] && (|(intr_q & ien_q));
  assign status = {fifo1_i, fifo2_i, |err_q, 1'b0, line_i, 1'b0, irq_o, mark_i};

  always_comb begin
    unique case (idx)
      RI_DATA:   rdata_o = data_i;
      RI_TIMER:  rdata_o = tmr_cnt;
      RI_ERR:    rdata_o = err_q;
      RI_MODE:   rdata_o = mode_q;
      RI_SEL:    rdata_o = sel_q;
      RI_SETUP:  rdata_o = setup_q;
      RI_CTRL:   rdata_o = ctrl_q;
      RI_STAT:   rdata_o = status;
      RI_INTR:   rdata_o = DW'(intr_q);
      RI_NSEEK:  rdata_o = nseek_q;
      RI_CTRACK: rdata_o = ctrack_i;
      RI_CSECT:  rdata_o = csect_i;
      RI_GAP:    rdata_o = gap_q;
      RI_SECTOR: rdata_o = sector_q;
      RI_NSECT:  rdata_o = nsect_q;
      RI_IEN:    rdata_o = DW'(ien_q);
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign setup_o  = setup_q;
  assign mode_o   = mode_q;
  assign select_o = sel_q;
  assign nseek_o  = nseek_q;
  assign gap_o    = gap_q;
  assign sector_o = sector_q;
  assign nsect_o  = nsect_q;
endmodule

// File: rtl/fdc_regfile_chk.sv
module fdc_regfile_chk
  import fdc_reg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] idx_i,
  input logic             wr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [IRQ_W-1:0] irq_src_i,
  input logic [DW-1:0]    err_src_i,
  input logic [DW-1:0]    setup_o,
  input logic [DW-1:0]    ctrl_o,
  input logic             irq_o,
  input logic [IRQ_W-1:0] intr_q,
  input logic [DW-1:0]    err_q
);
  // R3
  ctrl_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 4'd6 && !setup_o[7]) |=> ((ctrl_o & $past(wdata_i)) == '0));
  // R4
  ctrl_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 4'd7 && !setup_o[7]) |=> ((ctrl_o & $past(wdata_i)) == $past(wdata_i)));
  // R5
  intr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!setup_o[7]) |=> ((intr_q & $past(irq_src_i)) == $past(irq_src_i)));
  // R6
  err_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!setup_o[7]) |=> ((err_q & $past(err_src_i) & ERR_MASK) == ($past(err_src_i) & ERR_MASK)));
  // R6
  err_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q & ~ERR_MASK) == '0);
  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[0]) |-> !irq_o);
  // R10
  swrst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_o[7] |=> (ctrl_o == '0 && intr_q == '0 && err_q == '0));
endmodule

bind fdc_regfile fdc_regfile_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .idx_i     (idx),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .irq_src_i (irq_src_i),
  .err_src_i (err_src_i),
  .setup_o   (setup_o),
  .ctrl_o    (ctrl_o),
  .irq_o     (irq_o),
  .intr_q    (intr_q),
  .err_q     (err_q)
);

// File: tb/fdc_regfile_tb.sv
module fdc_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] data_in = '0, ctrack = '0, csect = '0;
  logic fifo1 = 1'b0, fifo2 = 1'b0, line = 1'b0, mark = 1'b0;
  logic [5:0] irq_src = '0;
  logic [7:0] err_src = '0;
  logic [7:0] ctrl, setup, mode, sel, nseek, gap, sector, nsect;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_regfile #(.ADDR_W(8), .STRIDE_LOG2(4), .CLK_PER_US(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .data_i(data_in), .ctrack_i(ctrack),
    .csect_i(csect), .fifo1_i(fifo1), .fifo2_i(fifo2), .line_i(line),
    .mark_i(mark), .irq_src_i(irq_src), .err_src_i(err_src), .ctrl_o(ctrl),
    .setup_o(setup), .mode_o(mode), .select_o(sel), .nseek_o(nseek),
    .gap_o(gap), .sector_o(sector), .nsect_o(nsect), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk);
    addr = {i, 4'h0}; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // driver: pushes expected read data, monitor compares
  task automatic rd_reg(input logic [3:0] i, input logic [7:0] exp, input string tag,
                        input logic [5:0] ev = '0, input logic [7:0] ee = '0,
                        input logic [3:0] lo = '0);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = {i, lo}; rd = 1'b1; irq_src = ev; err_src = ee;
    @(negedge clk);
    rd = 1'b0; irq_src = '0; err_src = '0;
  endtask

  task automatic pulse(input logic [5:0] ev, input logic [7:0] ee);
    @(negedge clk);
    irq_src = ev; err_src = ee;
    @(negedge clk);
    irq_src = '0; err_src = '0;
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (rd && exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk("R3 ctrl reset", ctrl, 8'h00);
    chk("R7 irq reset", {7'h0, irq}, 8'h00);
    rd_reg(4'd8, 8'h00, "R5 intr reset");
    rd_reg(4'd2, 8'h00, "R6 err reset");
    rd_reg(4'd1, 8'h00, "R9 timer reset");
    // plain registers
    wr_reg(4'd3, 8'h95);
    rd_reg(4'd3, 8'h95, "R1 low nibble ignored", '0, '0, 4'h3);
    chk("R2 mode_o", mode, 8'h95);
    wr_reg(4'd4, 8'h0A); rd_reg(4'd4, 8'h0A, "R2 select"); chk("R2 select_o", sel, 8'h0A);
    wr_reg(4'd13, 8'h12); rd_reg(4'd13, 8'h12, "R2 sector"); chk("R2 sector_o", sector, 8'h12);
    wr_reg(4'd14, 8'h03); chk("R2 nsect_o", nsect, 8'h03);
    wr_reg(4'd12, 8'h1B); rd_reg(4'd12, 8'h1B, "R2 gap"); chk("R2 gap_o", gap, 8'h1B);
    wr_reg(4'd9, 8'h05); rd_reg(4'd9, 8'h05, "R2 nseek"); chk("R2 nseek_o", nseek, 8'h05);
    wr_reg(4'd15, 8'hFF); rd_reg(4'd15, 8'h3F, "R2 ien width");
    wr_reg(4'd5, 8'h28); rd_reg(4'd5, 8'h28, "R2 setup"); chk("R2 setup_o", setup, 8'h28);
    // set/clear control
    wr_reg(4'd7, 8'h83); chk("R4 set", ctrl, 8'h83);
    wr_reg(4'd6, 8'h03); chk("R3 clear", ctrl, 8'h80);
    wr_reg(4'd7, 8'h21); chk("R4 set keeps", ctrl, 8'hA1);
    rd_reg(4'd6, 8'hA1, "R3 readback");
    // status layout
    @(negedge clk); fifo1 = 1; fifo2 = 1; line = 1; mark = 1;
    rd_reg(4'd7, 8'hC9, "R8 status lines");
    @(negedge clk); fifo1 = 0; fifo2 = 0; line = 0; mark = 0;
    rd_reg(4'd7, 8'h00, "R8 status idle");
    // interrupt latch and clear-on-read
    pulse(6'h08, 8'h00);
    chk("R7 irq up", {7'h0, irq}, 8'h01);
    rd_reg(4'd7, 8'h02, "R8 irq pending bit");
    rd_reg(4'd8, 8'h08, "R5 read with new event", 6'h04);
    chk("R5 event kept irq", {7'h0, irq}, 8'h01);
    rd_reg(4'd8, 8'h04, "R5 kept event");
    chk("R5 cleared irq", {7'h0, irq}, 8'h00);
    // masking
    wr_reg(4'd15, 8'h02);
    pulse(6'h04, 8'h00);
    chk("R7 masked", {7'h0, irq}, 8'h00);
    wr_reg(4'd6, 8'h01);
    wr_reg(4'd15, 8'h3F);
    chk("R7 master off", {7'h0, irq}, 8'h00);
    wr_reg(4'd7, 8'h01);
    chk("R7 master on", {7'h0, irq}, 8'h01);
    rd_reg(4'd8, 8'h04, "R5 flag held while masked");
    chk("R7 irq down", {7'h0, irq}, 8'h00);
    // error register
    pulse(6'h00, 8'hFF);
    rd_reg(4'd7, 8'h20, "R8 error bit");
    rd_reg(4'd2, 8'hC5, "R6 masked latch", 6'h00, 8'h40);
    rd_reg(4'd2, 8'h40, "R6 kept on read");
    rd_reg(4'd2, 8'h00, "R6 cleared");
    // timer
    wr_reg(4'd1, 8'd3);
    repeat (3*DIV - 3) @(negedge clk);
    rd_reg(4'd1, 8'd1, "R9 count before expiry");
    chk("R9 no irq before expiry", {7'h0, irq}, 8'h00);
    @(negedge clk);
    chk("R9 irq at expiry", {7'h0, irq}, 8'h01);
    rd_reg(4'd1, 8'd0, "R9 zero");
    rd_reg(4'd8, 8'h01, "R9 timer flag");
    repeat (2*DIV) @(negedge clk);
    rd_reg(4'd1, 8'd0, "R9 holds zero");
    rd_reg(4'd8, 8'h00, "R9 no second event");
    // core-driven registers
    @(negedge clk); ctrack = 8'h27; csect = 8'h0C; data_in = 8'h5A;
    rd_reg(4'd10, 8'h27, "R11 ctrack");
    wr_reg(4'd10, 8'h55);
    rd_reg(4'd10, 8'h27, "R11 ctrack write ignored");
    rd_reg(4'd11, 8'h0C, "R11 csect");
    rd_reg(4'd0, 8'h5A, "R11 data");
    // software reset
    wr_reg(4'd7, 8'hFF);
    pulse(6'h3F, 8'hFF);
    wr_reg(4'd5, 8'hA8);
    @(negedge clk);
    chk("R10 ctrl held", ctrl, 8'h00);
    chk("R10 irq low", {7'h0, irq}, 8'h00);
    wr_reg(4'd7, 8'h0F);
    chk("R10 set ignored", ctrl, 8'h00);
    pulse(6'h3F, 8'hFF);
    wr_reg(4'd5, 8'h28);
    rd_reg(4'd8, 8'h00, "R10 intr held");
    rd_reg(4'd2, 8'h00, "R10 err held");
    wr_reg(4'd7, 8'h02);
    chk("R10 control usable after", ctrl, 8'h02);
    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule